// File: doc/BRIEF.md
# Status register with condition codes

This block is the 16-bit processor status word of an integer core, together with the add/subtract flag logic that feeds it. Its lower byte is the user byte and holds five condition flags. Its upper byte is the system byte and holds an interrupt mask, a privilege bit and a single-step bit. Each cycle the block adds or subtracts two operands at byte, word or long size and presents the result. It computes carry, overflow, zero, negative and extend from that result. A per-flag enable chooses which of these flags are stored at the next clock edge.

Software-visible writes use one port with a separate enable for each byte. The user byte can be written at any privilege level. The system byte takes a write only while the privilege bit is set. In unprivileged mode the write is dropped and a violation pulse is raised. When the single-step bit is set, every instruction-completion strobe produces a one-cycle trap request. Bits with no function are tied to zero.

Top module: `status_word`

## Requirements
- R1: While rst_ni is low and after it rises, sr_o reads 16'h2700: privilege bit set, mask 3'b111, every other bit 0. priv_viol_o and trace_trap_o are 0.
- R2: size_i selects the operand width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 and 2'b11 are 32 bits. result_o carries op_a_i+op_b_i, or op_a_i-op_b_i when sub_i=1, in its low width bits. Bits of result_o above the width equal the same bits of op_a_i.
- R3: Carry (sr_o bit 0) is loaded with the carry out of the top bit of the width for an add, and with the borrow into that bit for a subtract.
- R4: Overflow (sr_o bit 1) is loaded with 1 exactly when the signed result at the selected width cannot be represented at that width.
- R5: Zero (sr_o bit 2) is loaded with 1 when the width-limited result is zero, and with 0 otherwise. Negative (sr_o bit 3) is loaded with the top bit of that result.
- R6: Extend (sr_o bit 4), when updated, takes the same value as the carry computed in that cycle.
- R7: flag_en_i bit k enables the update of sr_o bit k for k = 0..4 (C, V, Z, N, X). A flag whose enable is 0 keeps its value.
- R8: sr_o bits 5, 6, 7, 11, 12 and 14 always read 0, even after a write of ones.
- R9: When wr_en_i[0]=1, sr_o[4:0] is loaded from wr_data_i[4:0] in either privilege mode. This write takes precedence over flag updates in the same cycle.
- R10: When wr_en_i[1]=1 and sr_o bit 13 is 1, wr_data_i bits 10:8 load the mask, bit 13 loads the privilege bit and bit 15 loads the single-step bit.
- R11: When wr_en_i[1]=1 and sr_o bit 13 is 0, sr_o[15:8] does not change. priv_viol_o is 1 in the following cycle only.
- R12: trace_trap_o is 1 in the cycle after instr_done_i=1 if sr_o bit 15 was 1 in the cycle of the strobe, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | Destination operand (minuend for subtract) |
| op_b_i | input | 32 | Source operand (subtrahend for subtract) |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| size_i | input | 2 | Operand width code |
| flag_en_i | input | 5 | Per-flag update enable: X, N, Z, V, C from bit 4 down to bit 0 |
| result_o | output | 32 | Arithmetic result, with upper bits taken from op_a_i |
| wr_en_i | input | 2 | Write enable per byte: bit 1 system byte, bit 0 user byte |
| wr_data_i | input | 16 | Write data in status-word layout |
| instr_done_i | input | 1 | Instruction-completion strobe |
| sr_o | output | 16 | Current status word |
| priv_viol_o | output | 1 | Pulse for a system-byte write attempted without privilege |
| trace_trap_o | output | 1 | Single-step trap request |

## Verification
The byte width is swept over every source value against a spread of destination values, for both add and subtract. This covers every carry, borrow, overflow and zero combination at 8 bits. At word and long width, operands taken from zero, one, the largest positive, the smallest negative, all-ones and a mixed pattern probe the width boundary. These corners separate a carry or sign taken from the wrong bit, and an upper-bit pass-through taken from the wrong operand. The size code 3 is also exercised. Separate sequences check write precedence, the effect of partial enables, writes made with and without privilege, and trap strobes with single-step on and off.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W      = 16;
  localparam int CC_W      = 5;
  localparam int MASK_W    = 3;
  localparam int MASK_LSB  = 8;
  localparam int PRIV_BIT  = 13;
  localparam int STEP_BIT  = 15;
  localparam int NUM_SZ    = 3;
  localparam logic [15:0] SR_RESET = 16'h2700;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } op_size_e;

  // packed order matches user-byte bit positions 4..0
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import sr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] result_o,
  output cc_t               cc_o
);
  logic [DATA_W-1:0] res_s [NUM_SZ];
  logic [NUM_SZ-1:0] c_s, v_s, z_s, n_s;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
    localparam int W = 8 << k;
    logic [W:0]   ext;
    logic [W-1:0] low;

    assign ext = sub_i ? ({1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]})
                       : ({1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]});
    // carry/borrow into the top bit of the width
    assign low = sub_i ? ({1'b0, a_i[W-2:0]} - {1'b0, b_i[W-2:0]})
                       : ({1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]});

    assign c_s[k] = ext[W];
    assign v_s[k] = ext[W] ^ low[W-1];
    assign z_s[k] = (ext[W-1:0] == '0);
    assign n_s[k] = ext[W-1];

    if (W < DATA_W) begin : g_keep
      assign res_s[k] = {a_i[DATA_W-1:W], ext[W-1:0]};
    end else begin : g_full
      assign res_s[k] = ext[DATA_W-1:0];
    end
  end

  logic [1:0] idx;
  always_comb begin
    if (size_i[1])      idx = 2'd2;
    else if (size_i[0]) idx = 2'd1;
    else                idx = 2'd0;
  end

  always_comb begin
    result_o = res_s[idx];
    cc_o.c   = c_s[idx];
    cc_o.v   = v_s[idx];
    cc_o.z   = z_s[idx];
    cc_o.n   = n_s[idx];
    cc_o.x   = c_s[idx];
  end
endmodule

// File: rtl/sys_guard.sv
module sys_guard
  import sr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wr_byte_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              priv_o,
  output logic              step_o,
  output logic              viol_o
);
  localparam int PRIV_OFS = PRIV_BIT - 8;
  localparam int STEP_OFS = STEP_BIT - 8;

  logic              accept;
  logic [MASK_W-1:0] mask_q;
  logic              priv_q, step_q, viol_q;

  assign accept = wr_i & priv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= SR_RESET[MASK_LSB +: MASK_W];
      priv_q <= SR_RESET[PRIV_BIT];
      step_q <= SR_RESET[STEP_BIT];
      viol_q <= 1'b0;
    end else begin
      if (accept) begin
        mask_q <= wr_byte_i[MASK_W-1:0];
        priv_q <= wr_byte_i[PRIV_OFS];
        step_q <= wr_byte_i[STEP_OFS];
      end
      viol_q <= wr_i & ~priv_q;
    end
  end

  assign mask_o = mask_q;
  assign priv_o = priv_q;
  assign step_o = step_q;
  assign viol_o = viol_q;

  // R11
  sys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !priv_o) |=> $stable({step_o, priv_o, mask_o}));
  // R11
  viol_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !priv_o) |=> viol_o);
  // R11
  no_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !priv_o) |=> !viol_o);
  // R10
  sys_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && priv_o) |=> (mask_o == $past(wr_byte_i[MASK_W-1:0])));
endmodule

// File: rtl/step_trap.sv
module step_trap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic step_i,
  output logic trap_o
);
  logic trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= done_i & step_i;
  end

  assign trap_o = trap_q;

  // R12
  trap_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && step_i) |=> trap_o);
  // R12
  trap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && step_i) |=> !trap_o);
endmodule

// File: rtl/status_word.sv
module status_word
  import sr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              sub_i,
  input  logic [1:0]        size_i,
  input  logic [CC_W-1:0]   flag_en_i,
  output logic [DATA_W-1:0] result_o,
  input  logic [1:0]        wr_en_i,
  input  logic [SR_W-1:0]   wr_data_i,
  input  logic              instr_done_i,
  output logic [SR_W-1:0]   sr_o,
  output logic              priv_viol_o,
  output logic              trace_trap_o
);
  cc_t               calc_cc;
  logic [CC_W-1:0]   cc_q, cc_d;
  logic [MASK_W-1:0] mask;
  logic              priv, step;

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .sub_i   (sub_i),
    .size_i  (size_i),
    .result_o(result_o),
    .cc_o    (calc_cc)
  );

  always_comb begin
    cc_d = cc_q;
    if (wr_en_i[0]) begin
      cc_d = wr_data_i[CC_W-1:0];
    end else begin
      for (int i = 0; i < CC_W; i++)
        if (flag_en_i[i]) cc_d[i] = calc_cc[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cc_q <= SR_RESET[CC_W-1:0];
    else         cc_q <= cc_d;
  end

  sys_guard u_sys (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i[1]),
    .wr_byte_i(wr_data_i[15:8]),
    .mask_o   (mask),
    .priv_o   (priv),
    .step_o   (step),
    .viol_o   (priv_viol_o)
  );

  step_trap u_trap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(instr_done_i),
    .step_i(step),
    .trap_o(trace_trap_o)
  );

  assign sr_o = {step, 1'b0, priv, 2'b00, mask, 3'b000, cc_q};

  // R6
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i[4] && !wr_en_i[0]) |=> (sr_o[4] == $past(calc_cc.c)));
  // R7
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_en_i[0] && !wr_en_i[0]) |=> $stable(sr_o[0]));
  // R9
  user_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[0] |=> (sr_o[4:0] == $past(wr_data_i[4:0])));
  // R8
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o[7:5] == 3'b000) && (sr_o[12:11] == 2'b00) && !sr_o[14]);
endmodule

// File: tb/sim_status_word.sv
`timescale 1ns/1ps
module sim_status_word;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sub = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [4:0]  flag_en = '0;
  logic [31:0] result;
  logic [1:0]  wr_en = '0;
  logic [15:0] wr_data = '0;
  logic        done = 1'b0;
  logic [15:0] sr;
  logic        viol, trap;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  status_word u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_a_i(op_a), .op_b_i(op_b), .sub_i(sub),
    .size_i(size), .flag_en_i(flag_en), .result_o(result), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .instr_done_i(done), .sr_o(sr),
    .priv_viol_o(viol), .trace_trap_o(trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    op_a = '0; op_b = '0; sub = 0; size = 0; flag_en = 0; wr_en = 0; wr_data = 0; done = 0;
    @(negedge clk);
    chk("R1 in reset sr", {16'h0, sr}, 32'h2700);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one ALU op; called at a negedge, returns at a later negedge
  task automatic alu_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input logic [1:0] sz, input int w);
    longint mask, half, aw, bw, r, full, sa, sb, sres;
    bit c, v, z, n;
    logic [31:0] exp_res;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    aw = longint'(a) & mask;
    bw = longint'(b) & mask;
    if (!s) begin
      full = aw + bw; c = full > mask; r = full & mask;
    end else begin
      c = bw > aw; r = (aw - bw) & mask;
    end
    sa = (aw >= half) ? aw - (mask + 1) : aw;
    sb = (bw >= half) ? bw - (mask + 1) : bw;
    sres = s ? sa - sb : sa + sb;
    v = (sres < -half) || (sres > half - 1);
    z = (r == 0);
    n = (r >= half);
    exp_res = (a & ~mask[31:0]) | r[31:0];
    op_a = a; op_b = b; sub = s; size = sz; flag_en = 5'b11111;
    #1;
    chk("R2 result", result, exp_res);
    @(posedge clk);
    @(negedge clk);
    chk("R3 R4 R5 R6 flags", {27'h0, sr[4:0]}, {27'h0, c, n, z, v, c});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [6];
    do_reset();
    // R1
    chk("R1 sr after reset", {16'h0, sr}, 32'h2700);
    chk("R1 viol after reset", {31'h0, viol}, 32'h0);
    chk("R1 trap after reset", {31'h0, trap}, 32'h0);

    // byte sweep
    for (int ai = 0; ai < 256; ai += 7)
      for (int bi = 0; bi < 256; bi++)
        for (int s = 0; s < 2; s++)
          alu_op(32'hC3A5_9600 | ai, 32'h5A3C_E100 | bi, s[0], 2'b00, 8);

    // word and long corners
    for (int k = 0; k < 2; k++) begin
      int w;
      logic [31:0] m;
      w = (k == 0) ? 16 : 32;
      m = (k == 0) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      corner[0] = 32'h0;
      corner[1] = 32'h1;
      corner[2] = m >> 1;
      corner[3] = (m >> 1) + 1;
      corner[4] = m;
      corner[5] = 32'h9E37_79B9 & m;
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int s = 0; s < 2; s++)
            alu_op(corner[i] | (~m & 32'h7700_0000), corner[j], s[0], k[1:0] + 2'd1, w);
    end
    // R2: size code 3 acts as long
    alu_op(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b11, 32);
    alu_op(32'h0, 32'h1, 1'b1, 2'b11, 32);

    // R7: only carry enabled; others hold the written pattern
    wr_en = 2'b01; wr_data = 16'h0016; flag_en = 0;
    @(negedge clk);
    wr_en = 0;
    op_a = 32'hFF; op_b = 32'h01; sub = 0; size = 2'b00; flag_en = 5'b00001;
    @(negedge clk);
    chk("R7 partial enable", {27'h0, sr[4:0]}, {27'h0, 5'b10111});
    flag_en = 5'b00000;
    op_a = 32'h0; op_b = 32'h0;
    @(negedge clk);
    chk("R7 no enable holds", {27'h0, sr[4:0]}, {27'h0, 5'b10111});

    // R9: user write beats flag update
    op_a = 32'hFF; op_b = 32'h01; flag_en = 5'b11111;
    wr_en = 2'b01; wr_data = 16'h0009;
    @(negedge clk);
    wr_en = 0; flag_en = 0;
    chk("R9 write precedence", {27'h0, sr[4:0]}, 32'h9);

    // R8 R10: privileged write of all ones
    wr_en = 2'b11; wr_data = 16'hFFFF;
    @(negedge clk);
    wr_en = 0;
    chk("R8 R10 write ones", {16'h0, sr}, 32'hA71F);
    chk("R11 no viol when privileged", {31'h0, viol}, 32'h0);

    // R12: single-step on
    done = 1;
    @(negedge clk);
    done = 0;
    chk("R12 trap after done", {31'h0, trap}, 32'h1);
    @(negedge clk);
    chk("R12 trap one cycle", {31'h0, trap}, 32'h0);

    // R10: load mask 3'b010, privilege kept, step cleared
    wr_en = 2'b10; wr_data = 16'h2200;
    @(negedge clk);
    wr_en = 0;
    chk("R10 load mask", {16'h0, sr}, 32'h221F);
    done = 1;
    @(negedge clk);
    done = 0;
    chk("R12 no trap when step off", {31'h0, trap}, 32'h0);

    // drop privilege, then attempt system write
    wr_en = 2'b10; wr_data = 16'h0500;
    @(negedge clk);
    wr_en = 0;
    chk("R10 drop privilege", {16'h0, sr}, 32'h051F);
    wr_en = 2'b11; wr_data = 16'hA703;
    @(negedge clk);
    wr_en = 0;
    chk("R11 system byte ignored", {16'h0, sr}, 32'h0503);
    chk("R11 viol pulse", {31'h0, viol}, 32'h1);
    @(negedge clk);
    chk("R11 viol one cycle", {31'h0, viol}, 32'h0);
    chk("R9 user write in user mode", {27'h0, sr[4:0]}, 32'h3);

    do_reset();
    chk("R1 reset again", {16'h0, sr}, 32'h2700);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule